// File: doc/BRIEF.md
# Accumulator Requantization Output Stage

This block sits directly behind an integer matrix-multiply core. It turns each signed 32-bit accumulator into an unsigned 8-bit quantized activation in a single streaming pass, so no 32-bit intermediate result ever goes back to memory. Each element comes with its row and column index and with the precomputed sum of the activation row it came from. The column index selects that output channel's constants: the weight column sum, the weight zero point, the bias, the fixed-point multiplier, the shift amount and the output zero point.

Four pieces of arithmetic are applied in order. First, the offsets added by asymmetric quantization are removed and the bias is added. Second, the sum is rescaled with a fixed-point multiply and a rounding right shift. Third, the output zero point is added. Last, an optional ReLU clamp and saturation to the 8-bit range are applied. The pipeline has three register stages and accepts one element per cycle. A single enable, derived from the valid/ready handshake at the output, stalls all three stages together.

Top module: `acc_requant_stage`

## Requirements
- R1: While reset is asserted, and after it is released with no input, `out_valid` is 0 and `in_ready` is 1.
- R2: The corrected value is acc − a_zp·colsum[c] − wzp[c]·rowsum + K·a_zp·wzp[c]. The zero points a_zp and wzp are unsigned 8-bit. The column sum and row sum are signed 32-bit. K is unsigned 16-bit.
- R3: The signed 32-bit bias of the selected channel is added to the corrected value.
- R4: The sum from R2 and R3 is saturated to the signed 32-bit range before rescaling.
- R5: The saturated value is multiplied by the channel's signed 32-bit multiplier. The product is then shifted right by the channel's 6-bit shift amount, rounding half away from zero. A shift of 0 returns the exact product.
- R6: The channel's unsigned 8-bit output zero point is added to the rescaled value, and the result is saturated to 0..255.
- R7: With `cfg_relu_en` = 1, any negative rescaled value produces exactly the output zero point.
- R8: `in_col` selects which channel's constants are used. `out_row` and `out_col` leave the block together with their own result.
- R9: When the output is not stalled, an element accepted at clock edge a is presented on `out_valid`/`out_data` from edge a+2 and transfers at edge a+3. Results leave in the order the elements arrived.
- R10: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0, the outputs hold steady, and no element is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Block can accept an element this cycle |
| in_acc | input | 32 | Signed accumulator from the multiply core |
| in_rowsum | input | 32 | Signed sum of the activation row of this element |
| in_row | input | 10 | Row index tag |
| in_col | input | 3 | Column index, which selects the output channel |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_data | output | 8 | Quantized 8-bit result |
| out_row | output | 10 | Row tag of the result |
| out_col | output | 3 | Column tag of the result |
| cfg_a_zp | input | 8 | Activation zero point |
| cfg_k | input | 16 | Reduction depth K |
| cfg_relu_en | input | 1 | ReLU clamp enable |
| ch_colsum | input | 8x32 | Per-channel signed weight column sums |
| ch_wzp | input | 8x8 | Per-channel weight zero points |
| ch_bias | input | 8x32 | Per-channel signed bias |
| ch_mult | input | 8x32 | Per-channel signed fixed-point multiplier |
| ch_shift | input | 8x6 | Per-channel right-shift amount |
| ch_out_zp | input | 8x8 | Per-channel output zero point |

## Verification
The assertions assume that all configuration and per-channel inputs stay constant while any element is inside the pipeline. They also assume that `in_col` always names an existing channel. The ReLU floor check relies on the first of these assumptions. The stimulus changes constants or the ReLU enable only after the scoreboard queue has drained and the pipeline is empty, and it draws column indices only from the implemented channels. Backpressure is applied as random gaps in `out_ready` in one phase only, so that the fixed latency can be measured in the other phases.

// File: rtl/rq_pkg.sv
package rq_pkg;
    localparam int RQ_ACC_W = 32;
    localparam int RQ_ZP_W  = 8;
    localparam int RQ_K_W   = 16;
    localparam int RQ_SH_W  = 6;
    localparam int RQ_OUT_W = 8;
    localparam int RQ_ROW_W = 10;
    localparam int RQ_NCH   = 8;
endpackage

// File: rtl/rq_zp_bias.sv
module rq_zp_bias
    import rq_pkg::*;
#(
    parameter int ACC_W = RQ_ACC_W,
    parameter int ZP_W  = RQ_ZP_W,
    parameter int K_W   = RQ_K_W,
    parameter int ROW_W = RQ_ROW_W,
    parameter int NCH   = RQ_NCH,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int WIDE = 2 * ACC_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       vin,
    input  logic [ACC_W-1:0]           acc,
    input  logic [ACC_W-1:0]           rowsum,
    input  logic [ROW_W-1:0]           row,
    input  logic [CH_W-1:0]            col,
    input  logic [ZP_W-1:0]            a_zp,
    input  logic [K_W-1:0]             k_dim,
    input  logic [NCH-1:0][ACC_W-1:0]  colsum,
    input  logic [NCH-1:0][ZP_W-1:0]   wzp,
    input  logic [NCH-1:0][ACC_W-1:0]  bias,
    output logic                       vout,
    output logic [ACC_W-1:0]           corr,
    output logic [ROW_W-1:0]           row_o,
    output logic [CH_W-1:0]            col_o
);
    localparam logic signed [WIDE-1:0] HI = {{(WIDE-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [WIDE-1:0] LO = ~HI;

    logic signed [WIDE-1:0] x_acc, x_rs, x_cs, x_bias, x_azp, x_wzp, x_k, total;
    logic [ACC_W-1:0] sat32;

    always_comb begin
        x_acc  = {{(WIDE-ACC_W){acc[ACC_W-1]}}, acc};
        x_rs   = {{(WIDE-ACC_W){rowsum[ACC_W-1]}}, rowsum};
        x_cs   = {{(WIDE-ACC_W){colsum[col][ACC_W-1]}}, colsum[col]};
        x_bias = {{(WIDE-ACC_W){bias[col][ACC_W-1]}}, bias[col]};
        x_azp  = {{(WIDE-ZP_W){1'b0}}, a_zp};
        x_wzp  = {{(WIDE-ZP_W){1'b0}}, wzp[col]};
        x_k    = {{(WIDE-K_W){1'b0}}, k_dim};
        total  = x_acc - x_azp * x_cs - x_wzp * x_rs + x_k * x_azp * x_wzp + x_bias;
        if (total > HI)
            sat32 = HI[ACC_W-1:0];
        else if (total < LO)
            sat32 = LO[ACC_W-1:0];
        else
            sat32 = total[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vout  <= 1'b0;
            corr  <= '0;
            row_o <= '0;
            col_o <= '0;
        end else if (en) begin
            vout  <= vin;
            corr  <= sat32;
            row_o <= row;
            col_o <= col;
        end
    end
endmodule

// File: rtl/rq_scale.sv
module rq_scale
    import rq_pkg::*;
#(
    parameter int ACC_W = RQ_ACC_W,
    parameter int SH_W  = RQ_SH_W,
    parameter int ROW_W = RQ_ROW_W,
    parameter int NCH   = RQ_NCH,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int WIDE = 2 * ACC_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       vin,
    input  logic [ACC_W-1:0]           corr,
    input  logic [ROW_W-1:0]           row,
    input  logic [CH_W-1:0]            col,
    input  logic [NCH-1:0][ACC_W-1:0]  mult,
    input  logic [NCH-1:0][SH_W-1:0]   shift,
    output logic                       vout,
    output logic [WIDE-1:0]            scaled,
    output logic [ROW_W-1:0]           row_o,
    output logic [CH_W-1:0]            col_o
);
    localparam logic [WIDE-1:0] ONE = {{(WIDE-1){1'b0}}, 1'b1};

    logic signed [WIDE-1:0] x_c, x_m, prod;
    logic [WIDE-1:0] mag, half, rnd, res;
    logic neg;

    always_comb begin
        x_c  = {{(WIDE-ACC_W){corr[ACC_W-1]}}, corr};
        x_m  = {{(WIDE-ACC_W){mult[col][ACC_W-1]}}, mult[col]};
        prod = x_c * x_m;
        neg  = prod[WIDE-1];
        mag  = neg ? (~prod + ONE) : prod;
        half = (ONE << shift[col]) >> 1;
        rnd  = (mag + half) >> shift[col];
        res  = neg ? (~rnd + ONE) : rnd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vout   <= 1'b0;
            scaled <= '0;
            row_o  <= '0;
            col_o  <= '0;
        end else if (en) begin
            vout   <= vin;
            scaled <= res;
            row_o  <= row;
            col_o  <= col;
        end
    end

    // R5
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && vin && !corr[ACC_W-1] && !mult[col][ACC_W-1]) |=> !scaled[WIDE-1]);

    // R5
    zero_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && vin && corr == '0) |=> (scaled == '0));
endmodule

// File: rtl/rq_clamp.sv
module rq_clamp
    import rq_pkg::*;
#(
    parameter int ACC_W = RQ_ACC_W,
    parameter int OUT_W = RQ_OUT_W,
    parameter int ROW_W = RQ_ROW_W,
    parameter int NCH   = RQ_NCH,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int WIDE = 2 * ACC_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       vin,
    input  logic [WIDE-1:0]            scaled,
    input  logic [ROW_W-1:0]           row,
    input  logic [CH_W-1:0]            col,
    input  logic [NCH-1:0][OUT_W-1:0]  out_zp,
    input  logic                       relu_en,
    output logic                       vout,
    output logic [OUT_W-1:0]           data,
    output logic [ROW_W-1:0]           row_o,
    output logic [CH_W-1:0]            col_o
);
    localparam logic signed [WIDE-1:0] OMAX = {{(WIDE-OUT_W){1'b0}}, {OUT_W{1'b1}}};

    logic signed [WIDE-1:0] s_val, zp_x, shifted;
    logic [OUT_W-1:0] byte_v;

    always_comb begin
        s_val   = scaled;
        zp_x    = {{(WIDE-OUT_W){1'b0}}, out_zp[col]};
        shifted = s_val + zp_x;
        if (relu_en && s_val[WIDE-1])
            byte_v = out_zp[col];
        else if (shifted[WIDE-1])
            byte_v = '0;
        else if (shifted > OMAX)
            byte_v = OMAX[OUT_W-1:0];
        else
            byte_v = shifted[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vout  <= 1'b0;
            data  <= '0;
            row_o <= '0;
            col_o <= '0;
        end else if (en) begin
            vout  <= vin;
            data  <= byte_v;
            row_o <= row;
            col_o <= col;
        end
    end
endmodule

// File: rtl/acc_requant_stage.sv
module acc_requant_stage
    import rq_pkg::*;
#(
    parameter int ACC_W = RQ_ACC_W,
    parameter int ZP_W  = RQ_ZP_W,
    parameter int K_W   = RQ_K_W,
    parameter int SH_W  = RQ_SH_W,
    parameter int OUT_W = RQ_OUT_W,
    parameter int ROW_W = RQ_ROW_W,
    parameter int NCH   = RQ_NCH,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int WIDE = 2 * ACC_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [ACC_W-1:0]           in_acc,
    input  logic [ACC_W-1:0]           in_rowsum,
    input  logic [ROW_W-1:0]           in_row,
    input  logic [CH_W-1:0]            in_col,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [OUT_W-1:0]           out_data,
    output logic [ROW_W-1:0]           out_row,
    output logic [CH_W-1:0]            out_col,
    input  logic [ZP_W-1:0]            cfg_a_zp,
    input  logic [K_W-1:0]             cfg_k,
    input  logic                       cfg_relu_en,
    input  logic [NCH-1:0][ACC_W-1:0]  ch_colsum,
    input  logic [NCH-1:0][ZP_W-1:0]   ch_wzp,
    input  logic [NCH-1:0][ACC_W-1:0]  ch_bias,
    input  logic [NCH-1:0][ACC_W-1:0]  ch_mult,
    input  logic [NCH-1:0][SH_W-1:0]   ch_shift,
    input  logic [NCH-1:0][OUT_W-1:0]  ch_out_zp
);
    logic adv;
    logic v1, v2;
    logic [ACC_W-1:0] corr1;
    logic [WIDE-1:0]  scl2;
    logic [ROW_W-1:0] row1, row2;
    logic [CH_W-1:0]  col1, col2;

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    rq_zp_bias #(.ACC_W(ACC_W), .ZP_W(ZP_W), .K_W(K_W), .ROW_W(ROW_W), .NCH(NCH)) u_corr (
        .clk(clk), .rst_n(rst_n), .en(adv), .vin(in_valid),
        .acc(in_acc), .rowsum(in_rowsum), .row(in_row), .col(in_col),
        .a_zp(cfg_a_zp), .k_dim(cfg_k), .colsum(ch_colsum), .wzp(ch_wzp), .bias(ch_bias),
        .vout(v1), .corr(corr1), .row_o(row1), .col_o(col1)
    );

    rq_scale #(.ACC_W(ACC_W), .SH_W(SH_W), .ROW_W(ROW_W), .NCH(NCH)) u_scale (
        .clk(clk), .rst_n(rst_n), .en(adv), .vin(v1),
        .corr(corr1), .row(row1), .col(col1), .mult(ch_mult), .shift(ch_shift),
        .vout(v2), .scaled(scl2), .row_o(row2), .col_o(col2)
    );

    rq_clamp #(.ACC_W(ACC_W), .OUT_W(OUT_W), .ROW_W(ROW_W), .NCH(NCH)) u_clamp (
        .clk(clk), .rst_n(rst_n), .en(adv), .vin(v2),
        .scaled(scl2), .row(row2), .col(col2), .out_zp(ch_out_zp), .relu_en(cfg_relu_en),
        .vout(out_valid), .data(out_data), .row_o(out_row), .col_o(out_col)
    );

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_row) && $stable(out_col)));

    // R7
    relu_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_relu_en) |-> (out_data >= ch_out_zp[out_col]));
endmodule

// File: tb/acc_requant_stage_test.sv
module acc_requant_stage_test;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [31:0] in_acc = '0, in_rowsum = '0;
    logic [9:0] in_row = '0;
    logic [2:0] in_col = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [7:0] out_data;
    logic [9:0] out_row;
    logic [2:0] out_col;
    logic [7:0] cfg_a_zp = '0;
    logic [15:0] cfg_k = '0;
    logic cfg_relu_en = 1'b0;
    logic [NCH-1:0][31:0] ch_colsum, ch_bias, ch_mult;
    logic [NCH-1:0][7:0] ch_wzp, ch_out_zp;
    logic [NCH-1:0][5:0] ch_shift;

    int p_cs[NCH], p_wzp[NCH], p_bias[NCH], p_mult[NCH], p_sh[NCH], p_ozp[NCH];

    acc_requant_stage uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_acc(in_acc), .in_rowsum(in_rowsum), .in_row(in_row), .in_col(in_col),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_row(out_row), .out_col(out_col), .cfg_a_zp(cfg_a_zp), .cfg_k(cfg_k),
        .cfg_relu_en(cfg_relu_en), .ch_colsum(ch_colsum), .ch_wzp(ch_wzp),
        .ch_bias(ch_bias), .ch_mult(ch_mult), .ch_shift(ch_shift), .ch_out_zp(ch_out_zp)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [7:0] d;
        logic [9:0] row;
        logic [2:0] col;
        int cyc;
        bit lat;
        string req;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_bad = 0, cyc = 0;
    bit stall_mode = 0, prev_stall = 0, done = 0;
    logic [7:0] last_d;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [7:0] ref_out(longint acc, longint rs, int c);
        longint t, prod, mag, half, r, sc, v;
        t = acc - longint'(cfg_a_zp) * longint'(p_cs[c]) - longint'(p_wzp[c]) * rs
            + longint'(cfg_k) * longint'(cfg_a_zp) * longint'(p_wzp[c]) + longint'(p_bias[c]);
        if (t > 64'sd2147483647) t = 64'sd2147483647;
        if (t < -64'sd2147483648) t = -64'sd2147483648;
        prod = t * longint'(p_mult[c]);
        mag  = (prod < 0) ? -prod : prod;
        half = (p_sh[c] == 0) ? 64'sd0 : (64'sd1 <<< (p_sh[c] - 1));
        r    = (mag + half) >>> p_sh[c];
        sc   = (prod < 0) ? -r : r;
        if (cfg_relu_en && sc < 0) v = p_ozp[c];
        else v = sc + p_ozp[c];
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return v[7:0];
    endfunction

    task automatic apply_params();
        for (int c = 0; c < NCH; c++) begin
            ch_colsum[c] = p_cs[c];
            ch_wzp[c]    = p_wzp[c][7:0];
            ch_bias[c]   = p_bias[c];
            ch_mult[c]   = p_mult[c];
            ch_shift[c]  = p_sh[c][5:0];
            ch_out_zp[c] = p_ozp[c][7:0];
        end
    endtask

    task automatic send(logic [31:0] acc, logic [31:0] rs, logic [9:0] row, logic [2:0] col,
                        bit lat, string req);
        exp_t e;
        forever begin
            @(negedge clk); #2;
            in_acc = acc; in_rowsum = rs; in_row = row; in_col = col; in_valid = 1'b1;
            if (in_ready) break;
        end
        e.d = ref_out(longint'($signed(acc)), longint'($signed(rs)), int'(col));
        e.row = row; e.col = col; e.cyc = cyc; e.lat = lat; e.req = req;
        q.push_back(e);
    endtask

    task automatic idle_drain();
        @(negedge clk); #2; in_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            if (prev_stall) begin
                // R10 output held during stall
                check(out_valid === 1'b1 && out_data === last_d, "R10", out_data, last_d);
            end
            out_ready = stall_mode ? (($urandom % 4) != 0) : 1'b1;
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    check(1'b0, "R10", out_data, -1);
                end else begin
                    e = q.pop_front();
                    check(out_data === e.d, e.req, out_data, e.d);
                    // R8 tags travel with data
                    check(out_row === e.row && out_col === e.col, "R8", {out_row, out_col}, {e.row, e.col});
                    // R9 latency
                    if (e.lat) check((cyc - e.cyc) == 3, "R9", cyc - e.cyc, 3);
                end
            end
            prev_stall = out_valid && !out_ready;
            last_d = out_data;
            #1;
            // R10 input blocked while stalled
            if (out_valid && !out_ready) check(in_ready === 1'b0, "R10", in_ready, 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            p_cs[c] = 0; p_wzp[c] = 0; p_bias[c] = 0;
            p_mult[c] = 1 << 30; p_sh[c] = 31; p_ozp[c] = 128;
        end
        apply_params();
        repeat (3) @(negedge clk);
        // R1 during reset
        check(out_valid === 1'b0 && in_ready === 1'b1, "R1", out_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R1", out_valid, 0);

        // R6 zero point and saturation; R5 rounding ties, halves scale
        send(32'd0, 0, 10'd1, 3'd0, 1, "R6");
        send(32'd3, 0, 10'd2, 3'd1, 1, "R5");
        send(-32'sd3, 0, 10'd3, 3'd2, 1, "R5");
        send(32'd5, 0, 10'd4, 3'd3, 1, "R5");
        send(32'd1000, 0, 10'd5, 3'd4, 1, "R6");
        send(-32'sd1000, 0, 10'd6, 3'd5, 1, "R6");
        idle_drain();

        // R2 zero-point correction: 1000-300-200+240 = 740 -> /8 = 92.5 -> 93, +10 = 103
        cfg_a_zp = 8'd3; cfg_k = 16'd16;
        p_cs[2] = 100; p_wzp[2] = 5; p_mult[2] = 1 << 30; p_sh[2] = 33; p_ozp[2] = 10;
        // R3 bias on channel 3
        p_bias[3] = -500; p_sh[3] = 32; p_ozp[3] = 100;
        // R5 shift 0: exact product
        p_mult[7] = 1; p_sh[7] = 0; p_ozp[7] = 0;
        apply_params();
        @(negedge clk);
        send(32'd1000, 32'd40, 10'd7, 3'd2, 1, "R2");
        check(ref_out(1000, 40, 2) == 8'd103, "R2", ref_out(1000, 40, 2), 103);
        send(32'd600, 32'd0, 10'd8, 3'd3, 1, "R3");
        send(32'd77, 32'd0, 10'd9, 3'd7, 1, "R5");
        idle_drain();

        // R8 distinct per-channel constants
        for (int c = 0; c < NCH; c++) begin
            p_cs[c] = 10 * c - 20; p_wzp[c] = 3 * c + 1; p_bias[c] = 100 * c - 300;
            p_mult[c] = (1 << 30) + c * 1000; p_sh[c] = 30 + c; p_ozp[c] = 20 * c;
        end
        apply_params();
        @(negedge clk);
        for (int c = 0; c < NCH; c++) send(32'd5000, 32'd100, 10'(c), 3'(c), 1, "R8");
        idle_drain();

        // R4 intermediate saturation with extreme accumulators
        p_bias[1] = 32'h7fff_ffff; p_mult[1] = 1 << 30; p_sh[1] = 40; p_ozp[1] = 0;
        p_bias[6] = 32'h8000_0000; p_mult[6] = 1 << 30; p_sh[6] = 40; p_ozp[6] = 255;
        apply_params();
        @(negedge clk);
        send(32'h7fff_ffff, 32'd0, 10'd11, 3'd1, 1, "R4");
        send(32'h8000_0000, 32'd0, 10'd12, 3'd6, 1, "R4");
        send(32'h8000_0000, 32'h7fff_ffff, 10'd13, 3'd1, 1, "R4");
        idle_drain();

        // R7 ReLU: negatives give the output zero point
        cfg_relu_en = 1'b1;
        @(negedge clk);
        send(-32'sd90000, 32'd0, 10'd14, 3'd4, 1, "R7");
        send(-32'sd3, 32'd0, 10'd15, 3'd5, 1, "R7");
        send(32'd90000, 32'd0, 10'd16, 3'd4, 1, "R7");
        idle_drain();
        cfg_relu_en = 1'b0;

        // R10 random stream under backpressure
        stall_mode = 1;
        for (int i = 0; i < 300; i++)
            send($urandom, $urandom % 200000, 10'(i), 3'($urandom % NCH), 0, "R10");
        idle_drain();
        stall_mode = 0;
        idle_drain();
        finish_up();
    end
endmodule